// File: doc/BRIEF.md
# Cipher-Aware Dual-Instruction Fetch Stage

This block is the fetch stage of a 32-bit pipelined core whose program store may hold cipher-protected code. Each fetch reads one 64-bit block from instruction memory at the program counter. Every block carries two 32-bit instructions. With crypto mode off, the block is used as read. With crypto mode on, the block is sent to an external block-cipher port, and the stage waits for that port to finish before it uses the returned block. A two-way select picks the raw word or the cipher result. The selected block is split into its two instructions, which go to the IF pipeline register in two successive issue slots.

The cipher engine is outside the block. It is reached through a start/done handshake that also carries three 64-bit keys and a direction select. While the cipher is busy, the stage holds its program counter and issues bubbles. A taken branch or jump discards whatever is buffered or in flight and restarts fetching at the 8-byte block that contains the target.

The issue port is valid/ready. Valid is raised only while a buffered instruction is available and no redirect is present in the same cycle. When ready is low and no redirect arrives, valid stays high and the instruction and its address stay unchanged. An instruction counts as taken in a cycle where valid and ready are both high. The memory request side is also valid/ready (`imem_req_o`/`imem_gnt_i`), with the address held until grant. The memory answers with a single-cycle `imem_rvalid_i` in any later cycle. The cipher port must raise `cph_done_i` for one cycle, at least one cycle after the `cph_start_o` pulse.

Top module: `xfetch_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `if_valid_o` is low, the program counter is 0, a request for address 0 is presented, and crypto mode is off, so the first block is issued raw with no cipher start.
- R2: Each fully consumed block advances the program counter by 8. With no redirect, successive memory requests go to 0, 8, 16 and onward.
- R3: The low half of a block (bits 31:0) is issued first at the block address. The high half (bits 63:32) is issued next at the block address plus 4. Both halves come from a single memory access.
- R4: While `if_valid_o` is high and `if_ready_i` is low with no redirect, the next cycle still has `if_valid_o` high with `if_instr_o` and `if_pc_o` unchanged.
- R5: With crypto mode off, the issued instructions are the memory word halves unmodified. A word zero-padded in its high half issues its instruction followed by the all-zero NOP 0x00000000.
- R6: With crypto mode on, the memory word is presented on `cph_din_o` with a one-cycle `cph_start_o` pulse. `cph_decrypt_o` is 1 and the three keys are forwarded unchanged. The issued halves are those of `cph_dout_i`, captured when `cph_done_i` is high.
- R7: Between a cipher start and its done, `if_valid_o` is low, `if_instr_o` reads 0x00000000, no memory request is made, and the program counter does not change unless a redirect occurs.
- R8: In a cycle with `br_taken_i` high, `if_valid_o` is low. The buffered block is dropped. The next request goes to the target with address bits 2:0 cleared, and the first instruction issued afterwards is the low half of that block, even when target bit 2 is set.
- R9: A memory response or cipher result that was outstanding when a redirect occurred is discarded and never issued.
- R10: A cycle with `mode_wr_i` high loads crypto mode from `mode_on_i`. The new mode governs every block whose memory response arrives in a later cycle.
- R11: A memory request not granted keeps `imem_req_o` high with `imem_addr_o` unchanged in the following cycle unless a redirect occurs. Every request address is 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_i | input | 1 | Load crypto mode this cycle |
| mode_on_i | input | 1 | Crypto mode value to load |
| br_taken_i | input | 1 | Taken branch or jump, flushes the stage |
| br_target_i | input | ADDR_W | Redirect target byte address |
| imem_req_o | output | 1 | Memory read request valid |
| imem_gnt_i | input | 1 | Memory accepts the request |
| imem_addr_o | output | ADDR_W | Block byte address (8-byte aligned) |
| imem_rvalid_i | input | 1 | Read data valid |
| imem_rdata_i | input | BLK_W | 64-bit memory block |
| key1_i | input | KEY_W | First cipher key |
| key2_i | input | KEY_W | Second cipher key |
| key3_i | input | KEY_W | Third cipher key |
| cph_start_o | output | 1 | One-cycle cipher start |
| cph_decrypt_o | output | 1 | Cipher direction, 1 = decrypt |
| cph_din_o | output | BLK_W | Block handed to the cipher |
| cph_key1_o | output | KEY_W | First key to the cipher |
| cph_key2_o | output | KEY_W | Second key to the cipher |
| cph_key3_o | output | KEY_W | Third key to the cipher |
| cph_done_i | input | 1 | Cipher result valid |
| cph_dout_i | input | BLK_W | Cipher result block |
| if_valid_o | output | 1 | Instruction valid toward the IF register |
| if_ready_i | input | 1 | IF register accepts the instruction |
| if_instr_o | output | INSTR_W | Issued instruction, zero when not valid |
| if_pc_o | output | ADDR_W | Byte address of the issued instruction |

## Verification
Some properties are checked on every cycle by the assertions:
- the 8-byte program counter step and the realignment after a redirect,
- alignment of every request and a request held stable until grant,
- a single-cycle cipher start,
- bubbles and a frozen program counter while the cipher is busy,
- a stable issue port under back-pressure,
- no issue after a discarded cipher result.

Other properties can only be shown by the bench scenarios, which compare complete issued streams with values computed independently:
- that decryption actually reaches the issued instructions,
- the low-then-high lane order and the NOP from a zero-padded word,
- which blocks a mode write affects,
- that reset clears crypto mode,
- that a stale memory response or cipher result never appears in the stream.

// File: rtl/xfetch_pkg.sv
package xfetch_pkg;

  // Block-level fetch engine states
  typedef enum logic [2:0] {
    FS_REQ   = 3'd0,  // present memory request
    FS_MEM   = 3'd1,  // wait for memory response
    FS_START = 3'd2,  // pulse cipher start
    FS_CWAIT = 3'd3,  // wait for cipher done
    FS_FULL  = 3'd4   // block buffered, lanes being issued
  } fetch_st_t;

endpackage

// File: rtl/xfetch_pc.sv
module xfetch_pc #(
  parameter int              ADDR_W   = 32,
  parameter int              STEP     = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] pc_o
);

  localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(STEP);
  localparam logic [ADDR_W-1:0] ALIGN_M = ~(ADDR_W'(STEP - 1));

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          pc_q <= RESET_PC;
    else if (redirect_i) pc_q <= target_i & ALIGN_M;
    else if (advance_i)  pc_q <= pc_q + STEP_V;
  end

  assign pc_o = pc_q;

  // R2: one consumed block moves the counter by exactly one block
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !redirect_i) |=> (pc_q == $past(pc_q) + STEP_V));

  // R8: redirect lands on the block containing the target
  a_r8_realign: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (pc_q == ($past(target_i) & ALIGN_M)));

endmodule

// File: rtl/xfetch_engine.sv
module xfetch_engine
  import xfetch_pkg::*;
#(
  parameter int BLK_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             redirect_i,
  input  logic             consumed_i,
  input  logic             mode_wr_i,
  input  logic             mode_on_i,
  output logic             imem_req_o,
  input  logic             imem_gnt_i,
  input  logic             imem_rvalid_i,
  input  logic [BLK_W-1:0] imem_rdata_i,
  output logic             cph_start_o,
  output logic [BLK_W-1:0] cph_din_o,
  input  logic             cph_done_i,
  input  logic [BLK_W-1:0] cph_dout_i,
  output logic             busy_o,
  output logic             blk_valid_o,
  output logic [BLK_W-1:0] blk_data_o
);

  fetch_st_t        st_q;
  logic             drop_q;
  logic             mode_q;
  logic [BLK_W-1:0] din_q;
  logic [BLK_W-1:0] blk_q;
  logic             dec_path;
  logic [BLK_W-1:0] sel_word;

  // Raw/decrypted select: the cipher path is live only while waiting on it
  assign dec_path = (st_q == FS_CWAIT);
  assign sel_word = dec_path ? cph_dout_i : imem_rdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FS_REQ;
      drop_q <= 1'b0;
      mode_q <= 1'b0;
      din_q  <= '0;
      blk_q  <= '0;
    end else begin
      if (mode_wr_i) mode_q <= mode_on_i;
      unique case (st_q)
        FS_REQ: begin
          if (!redirect_i && imem_gnt_i) st_q <= FS_MEM;
        end
        FS_MEM: begin
          if (imem_rvalid_i) begin
            if (drop_q || redirect_i) begin
              st_q   <= FS_REQ;
              drop_q <= 1'b0;
            end else if (mode_q) begin
              din_q <= imem_rdata_i;
              st_q  <= FS_START;
            end else begin
              blk_q <= sel_word;
              st_q  <= FS_FULL;
            end
          end else if (redirect_i) begin
            drop_q <= 1'b1;
          end
        end
        FS_START: begin
          st_q <= FS_CWAIT;
          if (redirect_i) drop_q <= 1'b1;
        end
        FS_CWAIT: begin
          if (cph_done_i) begin
            if (drop_q || redirect_i) begin
              st_q   <= FS_REQ;
              drop_q <= 1'b0;
            end else begin
              blk_q <= sel_word;
              st_q  <= FS_FULL;
            end
          end else if (redirect_i) begin
            drop_q <= 1'b1;
          end
        end
        FS_FULL: begin
          if (redirect_i || consumed_i) st_q <= FS_REQ;
        end
        default: st_q <= FS_REQ;
      endcase
    end
  end

  assign imem_req_o  = (st_q == FS_REQ) && !redirect_i;
  assign cph_start_o = (st_q == FS_START);
  assign cph_din_o   = din_q;
  assign busy_o      = (st_q == FS_START) || (st_q == FS_CWAIT);
  assign blk_valid_o = (st_q == FS_FULL);
  assign blk_data_o  = blk_q;

  // R6: the cipher start is a single-cycle strobe
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cph_start_o |=> !cph_start_o);

  // R9: a result that arrives after a flush never becomes a buffered block
  a_r9_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_path && cph_done_i && drop_q) |=> !blk_valid_o);

  // R11: an ungranted request stays up with the same source state
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req_o && !imem_gnt_i) |=> (redirect_i || imem_req_o));

endmodule

// File: rtl/xfetch_split.sv
module xfetch_split #(
  parameter int              ADDR_W   = 32,
  parameter int              INSTR_W  = 32,
  parameter int              BLK_W    = 64,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_valid_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               flush_i,
  output logic               if_valid_o,
  input  logic               if_ready_i,
  output logic [INSTR_W-1:0] if_instr_o,
  output logic [ADDR_W-1:0]  if_pc_o,
  output logic               consumed_o
);

  localparam int LANES = BLK_W / INSTR_W;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LB    = $clog2(INSTR_W / 8);

  logic [INSTR_W-1:0] lane_w [LANES];
  logic [LW-1:0]      lane_q;
  logic               last;
  logic               fire;

  // Lane 0 is the lowest-addressed instruction of the block
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = blk_i[g*INSTR_W +: INSTR_W];
  end

  assign last       = (lane_q == LW'(LANES - 1));
  assign if_valid_o = blk_valid_i && !flush_i;
  assign fire       = if_valid_o && if_ready_i;
  assign consumed_o = fire && last;
  assign if_instr_o = if_valid_o ? lane_w[lane_q] : NOP_WORD;
  assign if_pc_o    = pc_i + (ADDR_W'(lane_q) << LB);

  always_ff @(posedge clk) begin
    if (!rst_n)       lane_q <= '0;
    else if (flush_i) lane_q <= '0;
    else if (fire)    lane_q <= last ? '0 : lane_q + LW'(1);
  end

  // R4: back-pressure keeps the offered instruction intact
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (if_valid_o && !if_ready_i && !flush_i) |=>
      (flush_i || (if_valid_o && $stable(if_instr_o) && $stable(if_pc_o))));

  // R3: a block is released only after its highest lane is taken
  a_r3_last_lane: assert property (@(posedge clk) disable iff (!rst_n)
    consumed_o |-> (if_pc_o[LB +: LW] == LW'(LANES - 1)));

endmodule

// File: rtl/xfetch_unit.sv
module xfetch_unit #(
  parameter int                ADDR_W      = 32,
  parameter int                INSTR_W     = 32,
  parameter int                BLK_W       = 64,
  parameter int                KEY_W       = 64,
  parameter logic [ADDR_W-1:0] RESET_PC    = '0,
  parameter bit                DECRYPT_SEL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr_i,
  input  logic               mode_on_i,
  input  logic               br_taken_i,
  input  logic [ADDR_W-1:0]  br_target_i,
  output logic               imem_req_o,
  input  logic               imem_gnt_i,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic               imem_rvalid_i,
  input  logic [BLK_W-1:0]   imem_rdata_i,
  input  logic [KEY_W-1:0]   key1_i,
  input  logic [KEY_W-1:0]   key2_i,
  input  logic [KEY_W-1:0]   key3_i,
  output logic               cph_start_o,
  output logic               cph_decrypt_o,
  output logic [BLK_W-1:0]   cph_din_o,
  output logic [KEY_W-1:0]   cph_key1_o,
  output logic [KEY_W-1:0]   cph_key2_o,
  output logic [KEY_W-1:0]   cph_key3_o,
  input  logic               cph_done_i,
  input  logic [BLK_W-1:0]   cph_dout_i,
  output logic               if_valid_o,
  input  logic               if_ready_i,
  output logic [INSTR_W-1:0] if_instr_o,
  output logic [ADDR_W-1:0]  if_pc_o
);

  localparam int STEP  = BLK_W / 8;
  localparam int OFF_W = $clog2(STEP);

  logic [ADDR_W-1:0] pc_w;
  logic              consumed_w;
  logic              advance_w;
  logic              busy_w;
  logic              blk_valid_w;
  logic [BLK_W-1:0]  blk_w;

  assign advance_w = consumed_w && !br_taken_i;

  xfetch_pc #(
    .ADDR_W  (ADDR_W),
    .STEP    (STEP),
    .RESET_PC(RESET_PC)
  ) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .redirect_i(br_taken_i),
    .target_i  (br_target_i),
    .advance_i (advance_w),
    .pc_o      (pc_w)
  );

  xfetch_engine #(
    .BLK_W(BLK_W)
  ) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .redirect_i   (br_taken_i),
    .consumed_i   (consumed_w),
    .mode_wr_i    (mode_wr_i),
    .mode_on_i    (mode_on_i),
    .imem_req_o   (imem_req_o),
    .imem_gnt_i   (imem_gnt_i),
    .imem_rvalid_i(imem_rvalid_i),
    .imem_rdata_i (imem_rdata_i),
    .cph_start_o  (cph_start_o),
    .cph_din_o    (cph_din_o),
    .cph_done_i   (cph_done_i),
    .cph_dout_i   (cph_dout_i),
    .busy_o       (busy_w),
    .blk_valid_o  (blk_valid_w),
    .blk_data_o   (blk_w)
  );

  xfetch_split #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W),
    .BLK_W   (BLK_W),
    .NOP_WORD('0)
  ) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_valid_i(blk_valid_w),
    .blk_i      (blk_w),
    .pc_i       (pc_w),
    .flush_i    (br_taken_i),
    .if_valid_o (if_valid_o),
    .if_ready_i (if_ready_i),
    .if_instr_o (if_instr_o),
    .if_pc_o    (if_pc_o),
    .consumed_o (consumed_w)
  );

  assign imem_addr_o   = pc_w;
  assign cph_decrypt_o = DECRYPT_SEL;
  assign cph_key1_o    = key1_i;
  assign cph_key2_o    = key2_i;
  assign cph_key3_o    = key3_i;

  // R7: cipher wait freezes the counter and issues only bubbles
  a_r7_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !br_taken_i) |=> $stable(pc_w));

  a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> (!if_valid_o && (if_instr_o == '0) && !imem_req_o));

  // R11: requests always name a whole block
  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_o |-> (imem_addr_o[OFF_W-1:0] == '0));

endmodule

// File: tb/xfetch_unit_tb_top.sv
`timescale 1ns/1ps
module xfetch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0, mode_on = 1'b0;
  logic        br_taken = 1'b0;
  logic [31:0] br_target = '0;
  logic        imem_req, imem_gnt = 1'b1;
  logic [31:0] imem_addr;
  logic        imem_rvalid;
  logic [63:0] imem_rdata;
  logic        cph_start, cph_decrypt, cph_done;
  logic [63:0] cph_din, cph_dout, ck1, ck2, ck3;
  logic        if_valid, if_ready = 1'b0;
  logic [31:0] if_instr, if_pc;

  localparam logic [63:0] K1 = 64'h0123456789abcdef;
  localparam logic [63:0] K2 = 64'h0f1e2d3c4b5a6978;
  localparam logic [63:0] K3 = 64'hdeadbeef00c0ffee;
  localparam logic [63:0] KX = K1 ^ K2 ^ K3;

  always #4 clk = ~clk;

  xfetch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr), .mode_on_i(mode_on),
    .br_taken_i(br_taken), .br_target_i(br_target),
    .imem_req_o(imem_req), .imem_gnt_i(imem_gnt), .imem_addr_o(imem_addr),
    .imem_rvalid_i(imem_rvalid), .imem_rdata_i(imem_rdata),
    .key1_i(K1), .key2_i(K2), .key3_i(K3),
    .cph_start_o(cph_start), .cph_decrypt_o(cph_decrypt), .cph_din_o(cph_din),
    .cph_key1_o(ck1), .cph_key2_o(ck2), .cph_key3_o(ck3),
    .cph_done_i(cph_done), .cph_dout_i(cph_dout),
    .if_valid_o(if_valid), .if_ready_i(if_ready),
    .if_instr_o(if_instr), .if_pc_o(if_pc)
  );

  function automatic logic [63:0] swp(input logic [63:0] x);
    return {x[31:0], x[63:32]};
  endfunction
  function automatic logic [63:0] encf(input logic [63:0] p);
    return swp(p ^ KX);
  endfunction
  function automatic logic [63:0] decf(input logic [63:0] c);
    return swp(c) ^ KX;
  endfunction
  function automatic logic [31:0] exp_ins(input logic [31:0] a);
    return (a[2] ? 32'h2000_0000 : 32'h1000_0000) + a;
  endfunction

  // Memory model: one-cycle read latency
  logic [63:0] mem [0:31];
  logic [31:0] req_log [0:63];
  int          n_req;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imem_rvalid <= 1'b0;
      n_req       <= 0;
    end else begin
      imem_rvalid <= imem_req && imem_gnt;
      if (imem_req && imem_gnt) begin
        imem_rdata <= mem[imem_addr[7:3]];
        if (n_req < 64) req_log[n_req] <= imem_addr;
        n_req <= n_req + 1;
      end
    end
  end

  // Reversible cipher stand-in with programmable latency
  int          lat = 2;
  int          ccnt;
  logic        cbusy;
  logic [63:0] din_log [0:15];
  logic        dec_seen, keys_ok;
  int          n_start;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cbusy    <= 1'b0;
      cph_done <= 1'b0;
      n_start  <= 0;
      keys_ok  <= 1'b1;
      dec_seen <= 1'b1;
    end else begin
      cph_done <= 1'b0;
      if (cph_start) begin
        cbusy <= 1'b1;
        ccnt  <= lat;
        if (n_start < 16) din_log[n_start] <= cph_din;
        n_start  <= n_start + 1;
        dec_seen <= dec_seen & cph_decrypt;
        keys_ok  <= keys_ok & (ck1 == K1) & (ck2 == K2) & (ck3 == K3);
      end else if (cbusy) begin
        if (ccnt <= 1) begin
          cbusy    <= 1'b0;
          cph_done <= 1'b1;
          cph_dout <= decf(din_log[n_start - 1]);
        end else begin
          ccnt <= ccnt - 1;
        end
      end
    end
  end

  int          n_chk = 0, n_err = 0;
  int          n_got, stall_bad, hold_bad, gnt_bad, bub;
  logic [31:0] got_i [0:63];
  logic [31:0] got_p [0:63];
  logic        p_vld, p_rdy, p_req, p_gnt;
  logic [31:0] p_ins, p_pc, p_addr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample();
    if (if_valid && if_ready && n_got < 64) begin
      got_i[n_got] = if_instr;
      got_p[n_got] = if_pc;
      n_got++;
    end
    if (cbusy) begin
      bub++;
      if (if_valid || imem_req || if_instr != 32'h0) stall_bad++;
    end
    if (p_vld && !p_rdy && !br_taken &&
        !(if_valid && if_instr == p_ins && if_pc == p_pc)) hold_bad++;
    if (p_req && !p_gnt && !br_taken &&
        !(imem_req && imem_addr == p_addr)) gnt_bad++;
    p_vld = if_valid; p_rdy = if_ready; p_ins = if_instr; p_pc = if_pc;
    p_req = imem_req; p_gnt = imem_gnt; p_addr = imem_addr;
  endtask

  // Sample the cycle with current inputs, then move past the next edge
  task automatic tick();
    #1;
    sample();
    @(negedge clk);
    #1;
  endtask

  task automatic apply_reset(input logic gnt);
    rst_n = 1'b0; if_ready = 1'b0; br_taken = 1'b0; mode_wr = 1'b0;
    imem_gnt = gnt;
    repeat (3) @(negedge clk);
    #1;
    n_got = 0; stall_bad = 0; hold_bad = 0; gnt_bad = 0; bub = 0;
    p_vld = 0; p_rdy = 0; p_req = 0; p_gnt = 0; p_ins = '0; p_pc = '0; p_addr = '0;
    rst_n = 1'b1;
  endtask

  task automatic run_until(input int n, input int max);
    for (int c = 0; c < max && n_got < n; c++) tick();
    if_ready = 1'b0;
  endtask

  task automatic load_mem(input bit enc);
    for (int i = 0; i < 32; i++) begin
      logic [63:0] p;
      p = {32'h2000_0000 + i*8 + 4, 32'h1000_0000 + i*8};
      mem[i] = enc ? encf(p) : p;
    end
  endtask

  task automatic write_mode(input logic on);
    mode_wr = 1'b1; mode_on = on;
    tick();
    mode_wr = 1'b0;
  endtask

  task automatic t_reset();
    load_mem(1'b0);
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk(!if_valid, "R1 valid low in reset", 64'(if_valid), 0);
    apply_reset(1'b1);
    chk(imem_req && imem_addr == 0, "R1 first request at 0", 64'(imem_addr), 0);
    write_mode(1'b1);
    apply_reset(1'b1);
    if_ready = 1'b1;
    run_until(2, 50);
    chk(got_i[0] == exp_ins(0), "R1 mode cleared, raw issue", 64'(got_i[0]), 64'(exp_ins(0)));
    chk(n_start == 0, "R1 no cipher start after reset", 64'(n_start), 0);
  endtask

  task automatic t_raw_stream();
    load_mem(1'b0);
    mem[1] = {32'h0, 32'h1000_0008};
    apply_reset(1'b1);
    if_ready = 1'b1;
    run_until(6, 100);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] e;
      e = (k == 3) ? 32'h0 : exp_ins(32'(k*4));
      chk(got_i[k] == e, "R5 raw instruction / zero-pad NOP", 64'(got_i[k]), 64'(e));
      chk(got_p[k] == 32'(k*4), "R3 lane address order", 64'(got_p[k]), 64'(k*4));
    end
    for (int k = 0; k < 3; k++)
      chk(req_log[k] == 32'(k*8), "R2 request advances by 8, one per block",
          64'(req_log[k]), 64'(k*8));
  endtask

  task automatic t_backpressure();
    load_mem(1'b0);
    apply_reset(1'b1);
    for (int c = 0; c < 200 && n_got < 6; c++) begin
      if_ready = (c % 3 == 2);
      tick();
    end
    if_ready = 1'b0;
    for (int k = 0; k < 6; k++)
      chk(got_i[k] == exp_ins(32'(k*4)) && got_p[k] == 32'(k*4),
          "R4 stream under back-pressure", 64'(got_i[k]), 64'(exp_ins(32'(k*4))));
    chk(hold_bad == 0, "R4 held instruction stable", 64'(hold_bad), 0);
  endtask

  task automatic t_crypto();
    load_mem(1'b1);
    apply_reset(1'b1);
    lat = 4;
    write_mode(1'b1);
    if_ready = 1'b1;
    run_until(4, 200);
    for (int k = 0; k < 4; k++)
      chk(got_i[k] == exp_ins(32'(k*4)) && got_p[k] == 32'(k*4),
          "R6 decrypted lane", 64'(got_i[k]), 64'(exp_ins(32'(k*4))));
    chk(din_log[0] == mem[0], "R6 memory word to cipher input", din_log[0], mem[0]);
    chk(dec_seen && keys_ok, "R6 decrypt select and keys forwarded", 64'({dec_seen, keys_ok}), 64'h3);
    chk(stall_bad == 0 && bub > 0, "R7 bubbles while cipher busy", 64'(stall_bad), 0);
  endtask

  task automatic t_redirect_full();
    load_mem(1'b0);
    apply_reset(1'b1);
    if_ready = 1'b1;
    run_until(1, 50);
    br_taken = 1'b1; br_target = 32'h1C; if_ready = 1'b1;
    #1;
    chk(!if_valid, "R8 valid low in redirect cycle", 64'(if_valid), 0);
    tick();
    br_taken = 1'b0;
    run_until(3, 50);
    chk(req_log[1] == 32'h18, "R8 request realigned", 64'(req_log[1]), 64'h18);
    chk(got_p[1] == 32'h18 && got_i[1] == exp_ins(32'h18), "R8 low lane first after redirect",
        64'(got_p[1]), 64'h18);
    chk(got_p[2] == 32'h1C && got_i[2] == exp_ins(32'h1C), "R8 high lane second",
        64'(got_p[2]), 64'h1C);
  endtask

  task automatic t_redirect_busy();
    load_mem(1'b1);
    apply_reset(1'b1);
    lat = 6;
    write_mode(1'b1);
    if_ready = 1'b1;
    for (int c = 0; c < 50 && !cbusy; c++) tick();
    br_taken = 1'b1; br_target = 32'h10;
    tick();
    br_taken = 1'b0;
    run_until(2, 200);
    chk(got_p[0] == 32'h10 && got_i[0] == exp_ins(32'h10), "R9 stale cipher result dropped",
        64'(got_p[0]), 64'h10);
    chk(din_log[1] == mem[2], "R9 refetch goes to cipher", din_log[1], mem[2]);
    // redirect while a memory response is outstanding
    load_mem(1'b0);
    apply_reset(1'b1);
    if_ready = 1'b1;
    tick();
    br_taken = 1'b1; br_target = 32'h08;
    tick();
    br_taken = 1'b0;
    run_until(1, 50);
    chk(got_p[0] == 32'h08 && got_i[0] == exp_ins(32'h08), "R9 stale memory response dropped",
        64'(got_p[0]), 64'h08);
  endtask

  task automatic t_mode_toggle();
    load_mem(1'b0);
    mem[0] = encf({32'h2000_0004, 32'h1000_0000});
    apply_reset(1'b1);
    lat = 2;
    write_mode(1'b1);
    if_ready = 1'b1;
    run_until(1, 100);
    write_mode(1'b0);
    if_ready = 1'b1;
    run_until(4, 100);
    for (int k = 0; k < 4; k++)
      chk(got_i[k] == exp_ins(32'(k*4)), "R10 mode change applies to later blocks",
          64'(got_i[k]), 64'(exp_ins(32'(k*4))));
    chk(n_start == 1, "R10 raw block bypasses cipher", 64'(n_start), 1);
  endtask

  task automatic t_grant();
    load_mem(1'b0);
    apply_reset(1'b0);
    if_ready = 1'b1;
    repeat (5) tick();
    chk(imem_req && n_req == 0, "R11 request waits for grant", 64'(n_req), 0);
    chk(gnt_bad == 0, "R11 request and address held", 64'(gnt_bad), 0);
    imem_gnt = 1'b1;
    run_until(2, 50);
    chk(got_p[0] == 0 && got_i[1] == exp_ins(4), "R11 fetch after late grant",
        64'(got_i[1]), 64'(exp_ins(4)));
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_raw_stream();
    t_backpressure();
    t_crypto();
    t_redirect_full();
    t_redirect_busy();
    t_mode_toggle();
    t_grant();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule